// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a simple host request port and a single 16-bit synchronous DRAM of 64 Mbit, organised as four banks of 4096 rows by 256 columns. The host presents one word request at a time on a valid/ready port, together with a 22-bit word address, write data and two byte enables. The controller splits the address into bank, row and column and opens the row with an activate command. It then issues a single-word read or write and closes the bank again with a precharge. Read data returns on a response strobe.

After reset the controller waits a programmable number of cycles. It then precharges all banks, issues two auto-refresh commands and loads the mode register, and only after that does it accept requests. A refresh timer derived from the clock frequency raises a refresh demand every 15.6 µs. When the controller is idle, that demand wins over the host. It is served by a precharge-all followed by an auto-refresh. A single down-counter enforces the minimum spacing between commands. The bidirectional data bus is split into an input bus, an output bus and an output enable.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: During reset the command is NOP, clock enable and `req_ready` are low. Clock enable is high from the first cycle after reset release. The first command is issued exactly `INIT_WAIT` cycles after reset release.
- R2: The start-up commands come in this order: precharge with A10 high, auto-refresh, auto-refresh, load-mode. `req_ready` stays low until the load-mode command has been issued.
- R3: The load-mode word carries `CAS_LAT` in A6..A4, with every other address bit and the bank bits at zero. This selects a burst of one, sequential order.
- R4: Commands are encoded on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} as: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto-refresh 0001, load-mode 0000.
- R5: The host address splits as bank = `req_addr[21:20]`, row = `req_addr[19:8]`, column = `req_addr[7:0]`. Activate drives the row on A11..A0. Read and write drive the column on A7..A0, with A11..A8 (so A10) low. Both drive the bank on `sd_ba`.
- R6: Every accepted request produces activate, then read or write, then a precharge of the same bank with A10 low. The precharge is the very next command.
- R7: Minimum cycles from one command to the next: `T_RCD` after activate, `T_RP` after precharge, `T_RC` after auto-refresh, `T_MRD` after load-mode, `T_WR` after write, `CAS_LAT` after read.
- R8: Clock enable is high in the cycle before every command.
- R9: `sd_dq_oe` is high only in a write command cycle. In that cycle `sd_dq_out` equals the write data. During read and write commands `sd_dqm[i]` is the inverse of byte enable i (lane 0 is bits 7..0). Elsewhere `sd_dqm` is 11.
- R10: Read data is sampled from `sd_dq_in` `CAS_LAT` cycles after the read command. `rsp_valid` pulses for one cycle in the cycle after that. Disabled byte lanes return zero.
- R11: After start-up, consecutive auto-refresh commands are at least `CLK_MHZ*156/10` cycles apart and less than 40 cycles more than that.
- R12: Each auto-refresh is directly preceded by a precharge with A10 high. No request is accepted `CLK_MHZ*156/10` or more cycles after the last auto-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address {bank,row,column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_addr | output | 12 | Multiplexed row/column/mode address |
| sd_ba | output | 2 | Bank select |
| sd_dqm | output | 2 | Byte masks, high masks the lane |
| sd_dq_out | output | 16 | Data toward memory |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | 16 | Data from memory |

## Verification
The hardest case is a host request that is waiting just as the refresh interval runs out. The refresh must then win and the request must wait until the refresh gap has passed. Nothing at the ports shows when the deadline falls. The bench therefore keeps streaming requests back to back, with no pause, across several refresh intervals, so that many accept opportunities land on and just past the deadline. Each accept is checked against the cycle of the last observed auto-refresh. A bench memory model answers reads with the masked lanes filled with a marker, so a wrong lane, a wrong address or a wrong capture cycle shows up as wrong data.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [3:0] {
        ST_INIT_PRE,
        ST_INIT_REF1,
        ST_INIT_REF2,
        ST_INIT_MODE,
        ST_IDLE,
        ST_ACT,
        ST_RW,
        ST_PRE,
        ST_REF_PRE,
        ST_REF
    } sdc_state_e;

    typedef logic [3:0] sdc_cmd_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam sdc_cmd_t CMD_NOP = 4'b0111;
    localparam sdc_cmd_t CMD_ACT = 4'b0011;
    localparam sdc_cmd_t CMD_RD  = 4'b0101;
    localparam sdc_cmd_t CMD_WR  = 4'b0100;
    localparam sdc_cmd_t CMD_PRE = 4'b0010;
    localparam sdc_cmd_t CMD_REF = 4'b0001;
    localparam sdc_cmd_t CMD_MRS = 4'b0000;

endpackage

// File: rtl/sdc_addr_split.sv
module sdc_addr_split #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    assign bank = addr[ADDR_W-1 -: BANK_W];
    assign row  = addr[COL_W +: ROW_W];
    assign col  = addr[COL_W-1:0];
endmodule

// File: rtl/sdc_gap_timer.sv
module sdc_gap_timer #(
    parameter int CNT_W     = 8,
    parameter int RESET_VAL = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CNT_W'(RESET_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
    parameter int INTERVAL = 780,
    localparam int CNT_W = $clog2(INTERVAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic due
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= CNT_W'(INTERVAL - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign due = (cnt == '0);
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdc_pkg::*;
#(
    parameter int CLK_MHZ   = 50,
    parameter int CAS_LAT   = 2,
    parameter int INIT_WAIT = 10000,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RC      = 7,
    parameter int T_MRD     = 2,
    parameter int T_WR      = 2,
    parameter int DATA_W    = 16,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic                            req_write,
    input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]               req_wdata,
    input  logic [DATA_W/8-1:0]             req_be,
    output logic                            rsp_valid,
    output logic [DATA_W-1:0]               rsp_rdata,
    output logic                            sd_cke,
    output logic                            sd_cs_n,
    output logic                            sd_ras_n,
    output logic                            sd_cas_n,
    output logic                            sd_we_n,
    output logic [ROW_W-1:0]                sd_addr,
    output logic [BANK_W-1:0]               sd_ba,
    output logic [DATA_W/8-1:0]             sd_dqm,
    output logic [DATA_W-1:0]               sd_dq_out,
    output logic                            sd_dq_oe,
    input  logic [DATA_W-1:0]               sd_dq_in
);
    localparam int LANES        = DATA_W / 8;
    localparam int REF_INTERVAL = CLK_MHZ * 156 / 10;
    localparam int GAP_MAX      = (INIT_WAIT > T_RC) ? INIT_WAIT : T_RC;
    localparam int GAP_W        = $clog2(GAP_MAX + 1);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    sdc_state_e state, state_nx;
    sdc_cmd_t   cmd;

    logic             gap_zero, gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             ref_due, ref_restart;
    logic             rd_issue, accept;
    logic [CAS_LAT-1:0] rd_pipe;

    logic [BANK_W-1:0] in_bank, q_bank;
    logic [ROW_W-1:0]  in_row,  q_row;
    logic [COL_W-1:0]  in_col,  q_col;
    logic              q_write;
    logic [DATA_W-1:0] q_wdata;
    logic [LANES-1:0]  q_be;

    sdc_addr_split #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr(req_addr), .bank(in_bank), .row(in_row), .col(in_col)
    );

    sdc_gap_timer #(.CNT_W(GAP_W), .RESET_VAL(INIT_WAIT)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
    );

    sdc_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk), .rst_n(rst_n), .restart(ref_restart), .due(ref_due)
    );

    assign req_ready = (state == ST_IDLE) && !ref_due;
    assign accept    = req_valid && req_ready;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_INIT_PRE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT_PRE:  if (gap_zero) state_nx = ST_INIT_REF1;
            ST_INIT_REF1: if (gap_zero) state_nx = ST_INIT_REF2;
            ST_INIT_REF2: if (gap_zero) state_nx = ST_INIT_MODE;
            ST_INIT_MODE: if (gap_zero) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (ref_due)        state_nx = ST_REF_PRE;
                else if (req_valid) state_nx = ST_ACT;
            end
            ST_ACT:     if (gap_zero) state_nx = ST_RW;
            ST_RW:      if (gap_zero) state_nx = ST_PRE;
            ST_PRE:     if (gap_zero) state_nx = ST_IDLE;
            ST_REF_PRE: if (gap_zero) state_nx = ST_REF;
            ST_REF:     if (gap_zero) state_nx = ST_IDLE;
        endcase
    end

    // Command and pin outputs; a command state waits for the gap counter
    always_comb begin
        cmd         = CMD_NOP;
        sd_addr     = '0;
        sd_ba       = '0;
        sd_dqm      = '1;
        sd_dq_out   = '0;
        sd_dq_oe    = 1'b0;
        gap_load    = 1'b0;
        gap_val     = '0;
        ref_restart = 1'b0;
        rd_issue    = 1'b0;
        unique case (state)
            ST_INIT_PRE, ST_REF_PRE: if (gap_zero) begin
                cmd         = CMD_PRE;
                sd_addr[10] = 1'b1;
                gap_load    = 1'b1;
                gap_val     = GAP_W'(T_RP - 1);
            end
            ST_INIT_REF1, ST_INIT_REF2, ST_REF: if (gap_zero) begin
                cmd         = CMD_REF;
                ref_restart = 1'b1;
                gap_load    = 1'b1;
                gap_val     = GAP_W'(T_RC - 1);
            end
            ST_INIT_MODE: if (gap_zero) begin
                cmd      = CMD_MRS;
                sd_addr  = MODE_WORD;
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_MRD - 1);
            end
            ST_IDLE: ;
            ST_ACT: if (gap_zero) begin
                cmd      = CMD_ACT;
                sd_addr  = q_row;
                sd_ba    = q_bank;
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_RCD - 1);
            end
            ST_RW: if (gap_zero) begin
                cmd      = q_write ? CMD_WR : CMD_RD;
                sd_addr  = ROW_W'(q_col);
                sd_ba    = q_bank;
                sd_dqm   = ~q_be;
                sd_dq_oe = q_write;
                sd_dq_out = q_write ? q_wdata : '0;
                rd_issue = !q_write;
                gap_load = 1'b1;
                gap_val  = q_write ? GAP_W'(T_WR - 1) : GAP_W'(CAS_LAT - 1);
            end
            ST_PRE: if (gap_zero) begin
                cmd      = CMD_PRE;
                sd_ba    = q_bank;
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_RP - 1);
            end
        endcase
    end

    // Request latch, clock enable and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_cke    <= 1'b0;
            q_write   <= 1'b0;
            q_bank    <= '0;
            q_row     <= '0;
            q_col     <= '0;
            q_wdata   <= '0;
            q_be      <= '0;
            rd_pipe   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            sd_cke  <= 1'b1;
            rd_pipe <= {rd_pipe[CAS_LAT-2:0], rd_issue};
            if (accept) begin
                q_write <= req_write;
                q_bank  <= in_bank;
                q_row   <= in_row;
                q_col   <= in_col;
                q_wdata <= req_wdata;
                q_be    <= req_be;
            end
            rsp_valid <= rd_pipe[CAS_LAT-1];
            if (rd_pipe[CAS_LAT-1]) begin
                for (int i = 0; i < LANES; i++)
                    rsp_rdata[8*i +: 8] <= q_be[i] ? sd_dq_in[8*i +: 8] : 8'h00;
            end
        end
    end

endmodule

// File: rtl/sdram_seq_ctrl_chk.sv
module sdram_seq_ctrl_chk
    import sdc_pkg::*;
#(
    parameter int CAS_LAT = 2,
    parameter int CLK_MHZ = 50
) (
    input logic clk,
    input logic rst_n,
    input logic sd_cke,
    input logic sd_cs_n,
    input logic sd_ras_n,
    input logic sd_cas_n,
    input logic sd_we_n,
    input logic sd_dq_oe,
    input logic rsp_valid,
    input logic req_valid,
    input logic req_ready
);
    localparam int REF_INTERVAL = CLK_MHZ * 156 / 10;

    sdc_cmd_t    cmd;
    logic [31:0] since_ref;
    logic        seen_ref;

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ref <= '0;
            seen_ref  <= 1'b0;
        end else if (cmd == CMD_REF) begin
            since_ref <= '0;
            seen_ref  <= 1'b1;
        end else if (since_ref != '1) begin
            since_ref <= since_ref + 1'b1;
        end
    end

    AST_CKE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> $past(sd_cke)); // R8

    AST_OE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (cmd == CMD_WR)); // R9

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd == CMD_RD, CAS_LAT + 1)); // R10

    AST_REFRESH_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        seen_ref |-> (since_ref < 32'(REF_INTERVAL + 40))); // R11

    AST_NO_ACCEPT_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_ref && req_valid && req_ready) |-> (since_ref < 32'(REF_INTERVAL - 1))); // R12

endmodule

bind sdram_seq_ctrl sdram_seq_ctrl_chk #(.CAS_LAT(CAS_LAT), .CLK_MHZ(CLK_MHZ)) u_chk (
    .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_dq_oe(sd_dq_oe), .rsp_valid(rsp_valid),
    .req_valid(req_valid), .req_ready(req_ready)
);

// File: tb/sdram_seq_ctrl_bench.sv
module sdram_seq_ctrl_bench;
    localparam int CL    = 2;
    localparam int IWAIT = 20;
    localparam int TRCD = 2, TRP = 2, TRC = 7, TMRD = 2, TWR = 2;
    localparam int RINT  = 50 * 156 / 10;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] sd_dq_in = '0;
    logic req_ready, rsp_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [15:0] rsp_rdata, sd_dq_out;
    logic [11:0] sd_addr;
    logic [1:0]  sd_ba, sd_dqm;

    always #10 clk = ~clk;

    sdram_seq_ctrl #(.CLK_MHZ(50), .CAS_LAT(CL), .INIT_WAIT(IWAIT)) u_sdram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    typedef struct { logic w; logic [21:0] a; logic [15:0] d; logic [1:0] be; } req_t;

    logic [15:0] host_mem [int];
    logic [15:0] dev_mem  [int];
    req_t        acc_q [$];
    req_t        cur;
    logic [15:0] rsp_exp_q [$];
    int          rsp_due_q [$];
    int          dq_due_q  [$];
    logic [15:0] dq_val_q  [$];
    int          open_row [4];
    logic [3:0]  last_cmd = 4'b0111;
    int          last_cyc = 0;
    bit          last_a10 = 1'b0;
    int          last_ref = -1;
    int          init_idx = 0;
    bit          prev_cke = 1'b0;

    function automatic int need(input logic [3:0] c);
        case (c)
            C_ACT:   return TRCD;
            C_PRE:   return TRP;
            C_REF:   return TRC;
            C_MRS:   return TMRD;
            C_WR:    return TWR;
            C_RD:    return CL;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // Reference model and comparison, once per clock away from the edge
    always @(negedge clk) begin
        logic [3:0]  c;
        logic [15:0] hv, dv;
        int          key;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (!rst_n) begin
            chk(c == C_NOP, "R1", "command in reset", 32'(c), 32'(C_NOP));
            chk(!sd_cke && !req_ready && !rsp_valid, "R1", "cke/ready/rsp in reset",
                {sd_cke, req_ready, rsp_valid}, 0);
            prev_cke = sd_cke;
        end else begin
            if (cyc == 1) chk(sd_cke, "R1", "cke after reset", 32'(sd_cke), 1);
            // memory model drives the read data in the capture cycle
            if (dq_due_q.size() > 0 && dq_due_q[0] == cyc) begin
                sd_dq_in = dq_val_q[0];
                void'(dq_due_q.pop_front());
                void'(dq_val_q.pop_front());
            end else begin
                sd_dq_in = 16'h5A3C;
            end
            // responses
            if (rsp_due_q.size() > 0 && rsp_due_q[0] == cyc) begin
                chk(rsp_valid, "R10", "rsp_valid", 32'(rsp_valid), 1);
                chk(rsp_rdata == rsp_exp_q[0], "R10", "read data", 32'(rsp_rdata), 32'(rsp_exp_q[0]));
                void'(rsp_due_q.pop_front());
                void'(rsp_exp_q.pop_front());
            end else if (rsp_valid) begin
                chk(1'b0, "R10", "unexpected rsp_valid", 1, 0);
            end
            if (init_idx < 4 && req_ready) chk(1'b0, "R2", "ready during start-up", 1, 0);
            // host handshake
            if (req_valid && req_ready) begin
                if (last_ref >= 0)
                    chk(cyc - last_ref < RINT, "R12", "accept after refresh due", 32'(cyc - last_ref), RINT);
                acc_q.push_back('{req_write, req_addr, req_wdata, req_be});
                hv = host_mem.exists(int'(req_addr)) ? host_mem[int'(req_addr)] : 16'h0;
                if (req_write)
                    host_mem[int'(req_addr)] = (hv & ~lane_mask(req_be)) | (req_wdata & lane_mask(req_be));
                else
                    rsp_exp_q.push_back(hv & lane_mask(req_be));
            end
            if (c != C_NOP) begin
                chk(prev_cke, "R8", "cke before command", 32'(prev_cke), 1);
                if (last_cmd != C_NOP)
                    chk(cyc - last_cyc >= need(last_cmd), "R7", "command gap",
                        32'(cyc - last_cyc), 32'(need(last_cmd)));
                if (init_idx >= 4 && (last_cmd == C_RD || last_cmd == C_WR))
                    chk(c == C_PRE && !sd_addr[10] && sd_ba == cur.a[21:20], "R6",
                        "bank close after access", {c, sd_addr[10]}, {C_PRE, 1'b0});
                if (init_idx < 4) begin
                    case (init_idx)
                        0: begin
                            chk(cyc == IWAIT, "R1", "first command cycle", 32'(cyc), IWAIT);
                            chk(c == C_PRE && sd_addr[10], "R2", "precharge-all first", {c, sd_addr[10]}, {C_PRE, 1'b1});
                        end
                        1, 2: chk(c == C_REF, "R2", "start-up refresh", 32'(c), 32'(C_REF));
                        default: begin
                            chk(c == C_MRS, "R2", "load-mode last", 32'(c), 32'(C_MRS));
                            chk(sd_addr == 12'(CL << 4) && sd_ba == 2'd0, "R3", "mode word",
                                {sd_ba, sd_addr}, 32'(CL << 4));
                        end
                    endcase
                    if (c == C_REF) last_ref = cyc;
                    init_idx++;
                end else begin
                    case (c)
                        C_ACT: begin
                            if (acc_q.size() == 0) chk(1'b0, "R6", "activate without request", 0, 1);
                            else begin
                                cur = acc_q.pop_front();
                                chk(sd_ba == cur.a[21:20], "R5", "activate bank", 32'(sd_ba), 32'(cur.a[21:20]));
                                chk(sd_addr == cur.a[19:8], "R5", "activate row", 32'(sd_addr), 32'(cur.a[19:8]));
                                open_row[sd_ba] = int'(sd_addr);
                            end
                        end
                        C_RD, C_WR: begin
                            chk((c == C_WR) == cur.w, "R6", "access direction", 32'(c), cur.w ? 32'(C_WR) : 32'(C_RD));
                            chk(sd_ba == cur.a[21:20] && sd_addr == {4'h0, cur.a[7:0]}, "R5", "column/bank",
                                {sd_ba, sd_addr}, {cur.a[21:20], 4'h0, cur.a[7:0]});
                            chk(sd_dqm == ~cur.be, "R9", "byte masks", 32'(sd_dqm), 32'(~cur.be));
                            key = (int'(sd_ba) << 20) | (open_row[sd_ba] << 8) | int'(sd_addr[7:0]);
                            dv = dev_mem.exists(key) ? dev_mem[key] : 16'h0;
                            if (c == C_WR) begin
                                chk(sd_dq_oe && sd_dq_out == cur.d, "R9", "write data",
                                    {sd_dq_oe, sd_dq_out}, {1'b1, cur.d});
                                dev_mem[key] = (dv & {{8{sd_dqm[1]}}, {8{sd_dqm[0]}}}) |
                                               (sd_dq_out & ~{{8{sd_dqm[1]}}, {8{sd_dqm[0]}}});
                            end else begin
                                chk(!sd_dq_oe, "R9", "no drive on read", 32'(sd_dq_oe), 0);
                                dq_due_q.push_back(cyc + CL);
                                dq_val_q.push_back({sd_dqm[1] ? 8'hA5 : dv[15:8], sd_dqm[0] ? 8'hA5 : dv[7:0]});
                                rsp_due_q.push_back(cyc + CL + 1);
                            end
                        end
                        C_PRE: ;
                        C_REF: begin
                            chk(last_cmd == C_PRE && last_a10, "R12", "precharge-all before refresh",
                                {last_cmd, last_a10}, {C_PRE, 1'b1});
                            chk(cyc - last_ref >= RINT && cyc - last_ref < RINT + 40, "R11",
                                "refresh spacing", 32'(cyc - last_ref), RINT);
                            last_ref = cyc;
                        end
                        default: chk(1'b0, "R4", "unexpected command code", 32'(c), 32'(C_NOP));
                    endcase
                end
                last_cmd = c;
                last_cyc = cyc;
                last_a10 = sd_addr[10];
            end
            prev_cke = sd_cke;
        end
    end

    task automatic host_req(input logic w, input logic [21:0] a, input logic [15:0] d, input logic [1:0] be);
        @(posedge clk); #2;
        req_write = w; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [21:0] pool [8];
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (40) @(posedge clk);
        // R5 field extremes, R9 lane masks
        host_req(1'b1, {2'd3, 12'hFFF, 8'hFF}, 16'hBEEF, 2'b11);
        host_req(1'b1, {2'd0, 12'h000, 8'h00}, 16'h1234, 2'b01);
        host_req(1'b1, {2'd1, 12'h5A5, 8'h3C}, 16'hCAFE, 2'b10);
        host_req(1'b1, {2'd2, 12'h0F0, 8'h81}, 16'h55AA, 2'b11);
        // R10 read back, full and partial lanes
        host_req(1'b0, {2'd3, 12'hFFF, 8'hFF}, 16'h0, 2'b11);
        host_req(1'b0, {2'd0, 12'h000, 8'h00}, 16'h0, 2'b11);
        host_req(1'b0, {2'd1, 12'h5A5, 8'h3C}, 16'h0, 2'b01);
        host_req(1'b0, {2'd2, 12'h0F0, 8'h81}, 16'h0, 2'b10);
        host_req(1'b1, {2'd2, 12'h0F0, 8'h81}, 16'h7700, 2'b10);
        host_req(1'b0, {2'd2, 12'h0F0, 8'h81}, 16'h0, 2'b11);
        // R11 idle refreshes
        repeat (2000) @(posedge clk);
        // R12 back-to-back stream across refresh deadlines
        for (int i = 0; i < 8; i++)
            pool[i] = {2'(i), 12'(i * 291), 8'(i * 37)};
        for (int i = 0; i < 1500; i++)
            host_req(1'($urandom % 2), pool[$urandom % 8], 16'($urandom), 2'($urandom % 4));
        repeat (50) @(posedge clk);
        chk(rsp_exp_q.size() == 0 && acc_q.size() == 0, "R10", "all requests answered",
            32'(rsp_exp_q.size()), 0);
        done = 1'b1;
        finish_run();
    end

endmodule